// File: doc/BRIEF.md
# PCI Configuration Port Decoder

This block sits on the I/O-space access path of a processor core. Each access arrives with a 16-bit port number, an access size, a direction and write data. The block decides where the access goes and returns that decision, with a physical target address, in the same cycle. It holds the 32-bit configuration-address register. A 4-byte access to port 0xCF8 reads or writes that register.

The four data ports from 0xCFC to 0xCFF use the stored register to reach configuration space. When bit 31 of the register (the enable bit) is set, the target is a configuration-window prefix ORed with register bits 30:2 and the port's two low bits. When the enable bit is clear, the block completes the access itself. Reads return all ones and writes are dropped. Every other port, and any access to 0xCF8 that is not 4 bytes wide, goes to a plain I/O window: an I/O prefix ORed with the port number.

The window prefixes, the widths and the two port numbers are parameters. The configuration backend and any I/O permission checks are outside this block.

Top module: `pci_cfg_port_decoder`

## Requirements
- R1: After reset the configuration-address register is zero, so a 4-byte read of port 0xCF8 returns 0.
- R2: A 4-byte access to port 0xCF8 has route_kind 3 (local) and route_addr 0. A write loads acc_wdata into the register at the next clock edge. A read returns the register on local_rdata with local_rdata_valid high.
- R3: An access to port 0xCF8 with acc_size other than 2 (size code 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved) goes to the I/O window and leaves the register unchanged.
- R4: An access to ports 0xCFC–0xCFF, matched on port bits 15:2, made while register bit 31 is 1, has route_kind 2 (configuration). Its route_addr is CFG_PREFIX OR (register bits 30:2 shifted left by 2) OR port bits 1:0.
- R5: A data-port access made while register bit 31 is 0 has route_kind 3 and route_addr 0. A read returns 32'hFFFF_FFFF with local_rdata_valid high. A write has no effect on the register.
- R6: Any other port has route_kind 1 (I/O), with route_addr equal to IO_PREFIX OR the zero-extended port number.
- R7: With acc_valid low, route_kind is 0, route_addr is 0, local_rdata_valid is 0 and the register holds its value.
- R8: A data-port or I/O-window write, enabled or not, never changes the configuration-address register.
- R9: local_rdata_valid is high only for local reads. In all other cases local_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_port | input | PORT_W | I/O port number |
| acc_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data |
| route_kind | output | 2 | 0 none, 1 I/O window, 2 configuration window, 3 local |
| route_addr | output | PADDR_W | Physical target for I/O and configuration routes, otherwise 0 |
| local_rdata | output | 32 | Data for local reads |
| local_rdata_valid | output | 1 | local_rdata carries read data |

## Verification
Every route output is a combinational function of the present access and the stored register. The bench drives each access after a falling edge and compares all four outputs before the next rising edge, in the same cycle. A write to the address register shows only on accesses issued after the following rising edge. The reference model therefore updates its own copy of the register at that edge, after the comparison for the writing access. Reads of 0xCF8 that come just after a write, a data-port write, or a misaligned access then show whether the register moved when it should and stayed put when it should not.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
   typedef enum logic [1:0] {
      RT_NONE  = 2'd0,
      RT_IO    = 2'd1,
      RT_CFG   = 2'd2,
      RT_LOCAL = 2'd3
   } route_e;

   typedef enum logic [1:0] {
      CL_IDLE  = 2'd0,
      CL_ADDR  = 2'd1,
      CL_DATA  = 2'd2,
      CL_OTHER = 2'd3
   } class_e;

   localparam logic [1:0] SZ_DWORD = 2'd2;
endpackage

// File: rtl/pcd_classifier.sv
module pcd_classifier
   import pcd_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter logic [PORT_W-1:0] ADDR_PORT = 16'hCF8,
   parameter logic [PORT_W-1:0] DATA_PORT = 16'hCFC
) (
   input  logic              valid,
   input  logic [PORT_W-1:0] port,
   input  logic [1:0]        size,
   output class_e            cls
);
   logic hit_addr;
   logic hit_data;

   assign hit_addr = (port == ADDR_PORT) && (size == SZ_DWORD);
   assign hit_data = (port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2]);

   always_comb begin
      if (!valid)        cls = CL_IDLE;
      else if (hit_addr) cls = CL_ADDR;
      else if (hit_data) cls = CL_DATA;
      else               cls = CL_OTHER;
   end
endmodule

// File: rtl/pcd_addr_reg.sv
module pcd_addr_reg #(
   parameter int          REG_W   = 32,
   parameter logic [REG_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REG_W-1:0] din,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= din;
   end
endmodule

// File: rtl/pcd_target.sv
module pcd_target
   import pcd_pkg::*;
#(
   parameter int PORT_W  = 16,
   parameter int PADDR_W = 64,
   parameter logic [PADDR_W-1:0] CFG_PREFIX = '0,
   parameter logic [PADDR_W-1:0] IO_PREFIX  = '0
) (
   input  class_e             cls,
   input  logic               write,
   input  logic [PORT_W-1:0]  port,
   input  logic [31:0]        cfg_q,
   output route_e             kind,
   output logic [PADDR_W-1:0] addr,
   output logic [31:0]        rdata,
   output logic               rdata_valid
);
   localparam int OFS_W = 31;

   logic [PADDR_W-1:0] cfg_ofs;
   logic [PADDR_W-1:0] io_ofs;
   logic               cfg_en;

   assign cfg_en = cfg_q[31];

   generate
      if (PADDR_W > OFS_W) begin : g_wide_cfg
         assign cfg_ofs = {{(PADDR_W-OFS_W){1'b0}}, cfg_q[30:2], port[1:0]};
      end else begin : g_exact_cfg
         assign cfg_ofs = {cfg_q[30:2], port[1:0]};
      end
      if (PADDR_W > PORT_W) begin : g_wide_io
         assign io_ofs = {{(PADDR_W-PORT_W){1'b0}}, port};
      end else begin : g_exact_io
         assign io_ofs = port;
      end
   endgenerate

   always_comb begin
      kind        = RT_NONE;
      addr        = '0;
      rdata       = '0;
      rdata_valid = 1'b0;
      unique case (cls)
         CL_IDLE: ;
         CL_ADDR: begin
            kind        = RT_LOCAL;
            rdata       = write ? 32'h0 : cfg_q;
            rdata_valid = !write;
         end
         CL_DATA: begin
            if (cfg_en) begin
               kind = RT_CFG;
               addr = CFG_PREFIX | cfg_ofs;
            end else begin
               kind        = RT_LOCAL;
               rdata       = write ? 32'h0 : 32'hFFFF_FFFF;
               rdata_valid = !write;
            end
         end
         CL_OTHER: begin
            kind = RT_IO;
            addr = IO_PREFIX | io_ofs;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pci_cfg_port_decoder.sv
module pci_cfg_port_decoder
   import pcd_pkg::*;
#(
   parameter int PORT_W  = 16,
   parameter int PADDR_W = 64,
   parameter logic [PORT_W-1:0]  ADDR_PORT  = 16'hCF8,
   parameter logic [PORT_W-1:0]  DATA_PORT  = 16'hCFC,
   parameter logic [PADDR_W-1:0] CFG_PREFIX = 64'hC000_0000_0000_0000,
   parameter logic [PADDR_W-1:0] IO_PREFIX  = 64'h8000_0000_0000_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [PORT_W-1:0]  acc_port,
   input  logic [1:0]         acc_size,
   input  logic               acc_write,
   input  logic [31:0]        acc_wdata,
   output logic [1:0]         route_kind,
   output logic [PADDR_W-1:0] route_addr,
   output logic [31:0]        local_rdata,
   output logic               local_rdata_valid
);
   localparam int REG_W = 32;

   initial begin
      if (PORT_W < 3 || PORT_W > PADDR_W)
         $error("PORT_W must be between 3 and PADDR_W");
      if (PADDR_W < REG_W)
         $error("PADDR_W must be at least 32");
      if (DATA_PORT[1:0] != 2'b00)
         $error("DATA_PORT must be 4-aligned");
      if (ADDR_PORT[PORT_W-1:2] == DATA_PORT[PORT_W-1:2])
         $error("ADDR_PORT must not fall in the data-port group");
   end

   class_e           cls;
   route_e           kind;
   logic [REG_W-1:0] cfg_q;
   logic             cfg_load;

   pcd_classifier #(
      .PORT_W(PORT_W), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
   ) u_cls (
      .valid(acc_valid), .port(acc_port), .size(acc_size), .cls(cls)
   );

   assign cfg_load = (cls == CL_ADDR) && acc_write;

   pcd_addr_reg #(.REG_W(REG_W), .RST_VAL('0)) u_reg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .din(acc_wdata), .q(cfg_q)
   );

   pcd_target #(
      .PORT_W(PORT_W), .PADDR_W(PADDR_W),
      .CFG_PREFIX(CFG_PREFIX), .IO_PREFIX(IO_PREFIX)
   ) u_tgt (
      .cls(cls), .write(acc_write), .port(acc_port), .cfg_q(cfg_q),
      .kind(kind), .addr(route_addr), .rdata(local_rdata),
      .rdata_valid(local_rdata_valid)
   );

   assign route_kind = kind;
endmodule

// File: rtl/pcd_chk.sv
module pcd_chk #(
   parameter int PORT_W  = 16,
   parameter int PADDR_W = 64,
   parameter logic [PORT_W-1:0]  ADDR_PORT = 16'hCF8,
   parameter logic [PORT_W-1:0]  DATA_PORT = 16'hCFC,
   parameter logic [PADDR_W-1:0] IO_PREFIX = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic [PORT_W-1:0]  acc_port,
   input logic [1:0]         acc_size,
   input logic               acc_write,
   input logic [1:0]         route_kind,
   input logic [PADDR_W-1:0] route_addr,
   input logic [31:0]        local_rdata,
   input logic               local_rdata_valid,
   input logic [31:0]        cfg_q
);
   logic addr_wr;
   logic data_grp;
   assign addr_wr  = acc_valid && acc_write && acc_port == ADDR_PORT && acc_size == 2'd2;
   assign data_grp = acc_port[PORT_W-1:2] == DATA_PORT[PORT_W-1:2];

   // R2
   reg_load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_q) |-> $past(addr_wr));

   // R4
   cfg_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_kind == 2'd2 |-> cfg_q[31] && acc_valid && data_grp);

   // R5
   disabled_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && data_grp && !cfg_q[31]) |-> local_rdata == 32'hFFFF_FFFF);

   // R6
   io_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_kind == 2'd1 |-> route_addr[PORT_W-1:0] == acc_port
                             && (route_addr & IO_PREFIX) == IO_PREFIX);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> route_kind == 2'd0 && route_addr == '0 && !local_rdata_valid);

   // R9
   rdata_valid_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      local_rdata_valid |-> route_kind == 2'd3 && !acc_write && acc_size == acc_size);
endmodule

bind pci_cfg_port_decoder pcd_chk #(
   .PORT_W(PORT_W), .PADDR_W(PADDR_W), .ADDR_PORT(ADDR_PORT),
   .DATA_PORT(DATA_PORT), .IO_PREFIX(IO_PREFIX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_port(acc_port),
   .acc_size(acc_size), .acc_write(acc_write), .route_kind(route_kind),
   .route_addr(route_addr), .local_rdata(local_rdata),
   .local_rdata_valid(local_rdata_valid), .cfg_q(cfg_q)
);

// File: tb/pci_cfg_port_decoder_tb.sv
module pci_cfg_port_decoder_tb;
   localparam logic [63:0] CFGP = 64'hC000_0000_0000_0000;
   localparam logic [63:0] IOP  = 64'h8000_0000_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [15:0] acc_port = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_write = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [1:0]  route_kind;
   logic [63:0] route_addr;
   logic [31:0] local_rdata;
   logic        local_rdata_valid;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [31:0] model_reg = '0;

   always #5 clk = ~clk;

   pci_cfg_port_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_port(acc_port),
      .acc_size(acc_size), .acc_write(acc_write), .acc_wdata(acc_wdata),
      .route_kind(route_kind), .route_addr(route_addr),
      .local_rdata(local_rdata), .local_rdata_valid(local_rdata_valid)
   );

   task automatic access(input bit v, input logic [15:0] p, input logic [1:0] sz,
                         input bit w, input logic [31:0] d, input string req);
      logic [1:0]  ek;
      logic [63:0] ea;
      logic [31:0] ed;
      logic        ev;
      bit          is_addr;
      @(negedge clk);
      acc_valid = v; acc_port = p; acc_size = sz; acc_write = w; acc_wdata = d;
      #2;
      is_addr = v && p == 16'hCF8 && sz == 2'd2;
      ek = 2'd0; ea = '0; ed = '0; ev = 1'b0;
      if (!v) begin
      end else if (is_addr) begin
         ek = 2'd3; ev = !w; ed = w ? 32'h0 : model_reg;
      end else if (p[15:2] == 14'(16'hCFC >> 2)) begin
         if (model_reg[31]) begin
            ek = 2'd2; ea = CFGP | {33'h0, model_reg[30:2], p[1:0]};
         end else begin
            ek = 2'd3; ev = !w; ed = w ? 32'h0 : 32'hFFFF_FFFF;
         end
      end else begin
         ek = 2'd1; ea = IOP | {48'h0, p};
      end
      checks++;
      if (route_kind !== ek || route_addr !== ea || local_rdata !== ed
          || local_rdata_valid !== ev) begin
         failures++;
         $display("FAIL %s: kind=%0d addr=%h rdata=%h rv=%b expected kind=%0d addr=%h rdata=%h rv=%b",
                  req, route_kind, route_addr, local_rdata, local_rdata_valid,
                  ek, ea, ed, ev);
      end
      @(posedge clk);
      if (is_addr && w) model_reg = d;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset value
      access(1, 16'hCF8, 2'd2, 0, 0, "R1");
      // R7: idle
      access(0, 16'hCFC, 2'd2, 1, 32'hDEAD_BEEF, "R7");
      // R5: disabled data port read and write
      access(1, 16'hCFC, 2'd2, 0, 0, "R5");
      access(1, 16'hCFE, 2'd0, 1, 32'h1234_5678, "R5");
      access(1, 16'hCF8, 2'd2, 0, 0, "R5");
      // R2: load register, read back
      access(1, 16'hCF8, 2'd2, 1, 32'h8012_3458, "R2");
      access(1, 16'hCF8, 2'd2, 0, 0, "R2");
      // R4: enabled data ports, all four low-bit values
      for (int i = 0; i < 4; i++)
         access(1, 16'hCFC + 16'(i), 2'(i % 3), i[0], 32'hA5A5_0000, "R4");
      // R8: data-port write leaves register
      access(1, 16'hCFD, 2'd2, 1, 32'h0000_0000, "R8");
      access(1, 16'hCF8, 2'd2, 0, 0, "R8");
      // R3: narrow accesses to address port
      access(1, 16'hCF8, 2'd0, 1, 32'h0000_0000, "R3");
      access(1, 16'hCF8, 2'd1, 0, 0, "R3");
      access(1, 16'hCF8, 2'd3, 1, 32'h0, "R3");
      access(1, 16'hCF8, 2'd2, 0, 0, "R3");
      // R6: other ports incl. neighbours
      access(1, 16'h0080, 2'd0, 1, 32'h11, "R6");
      access(1, 16'hCFB, 2'd2, 0, 0, "R6");
      access(1, 16'hCF9, 2'd2, 0, 0, "R6");
      access(1, 16'hD00, 2'd1, 0, 0, "R6");
      access(1, 16'hFFFF, 2'd2, 1, 32'h22, "R6");
      access(1, 16'h0CFC ^ 16'h1000, 2'd2, 0, 0, "R6");
      // R8: I/O write leaves register
      access(1, 16'hCF8, 2'd2, 0, 0, "R8");
      // R2: rewrite with other pattern, enable clear again
      access(1, 16'hCF8, 2'd2, 1, 32'h7FFF_FFFF, "R2");
      access(1, 16'hCFF, 2'd2, 0, 0, "R5");
      access(1, 16'hCF8, 2'd2, 1, 32'hFFFF_FFFF, "R2");
      access(1, 16'hCFF, 2'd1, 0, 0, "R4");
      // R9: writes produce no read data
      access(1, 16'hCF8, 2'd2, 1, 32'h8000_0004, "R9");
      access(1, 16'hCFC, 2'd2, 1, 32'h0, "R9");
      access(0, 16'hCF8, 2'd2, 0, 0, "R9");
      // R1: reset again clears register
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_reg = '0;
      access(1, 16'hCF8, 2'd2, 0, 0, "R1");
      access(1, 16'hCFC, 2'd2, 0, 0, "R1");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule